// File: doc/BRIEF.md
# Operand Effective Address Unit

This block works out where an instruction operand lives for a small processor with 16-bit byte addresses and 4-byte words. A request carries a 3-bit mode code, a direction bit, a register index, a 16-bit constant field from the instruction and the address of the following instruction. The block returns one of three things. It can give the content of a register as the operand. It can give the constant as an immediate operand. Otherwise it gives a memory byte address. It reads the register file through one combinational read port. For the auto-stepping modes it writes the stepped base register back through one write port.

Requests enter on a valid/ready stream. `req_ready` is high only while the block is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. Results leave on a second valid/ready stream. Once `res_valid` rises, the result stays unchanged until `res_ready` is seen high, so a stalled consumer loses nothing. The memory-indirect mode issues one word read to memory. `mem_req` and `mem_addr` stay steady until memory answers with a one-cycle `mem_ack` pulse carrying `mem_rdata`. All address arithmetic wraps modulo 2^16.

Result kind codes on `res_kind`: 0 = register operand, 1 = immediate operand, 2 = memory address.

Top module: `oea_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1, and `res_valid`, `mem_req` and `rf_we` are 0.
- R2: Mode 0 (register) returns kind 0 with the content of register `req_idx`. It issues no memory read and no register write.
- R3: Mode 1 (absolute) returns kind 2 with `req_konst` as the address.
- R4: Mode 2 (immediate) returns kind 1 with `req_konst` as the operand.
- R5: Mode 3 (register indirect) returns kind 2 with the content of register `req_idx`.
- R6: Mode 4 (memory indirect) raises `mem_req` with `mem_addr` = `req_konst` in the cycle after acceptance and holds both steady until `mem_ack`. In the cycle after `mem_ack`, it returns kind 2 with the `mem_rdata` captured at the ack.
- R7: Mode 5 (indexed) returns kind 2 with register + `req_konst` mod 2^16, and the register keeps its value.
- R8: Mode 6 (relative) returns kind 2 with `req_pc` + `req_konst` mod 2^16, where `req_pc` is the next-instruction address.
- R9: Mode 7 with `req_dec` = 0 (autoincrement) returns kind 2 with the register content. The register is then written with that content + 4.
- R10: Mode 7 with `req_dec` = 1 (autodecrement) returns kind 2 with register − 4 mod 2^16. The register is written with that same value.
- R11: For every mode except 4, `res_valid` rises in the cycle after acceptance. `req_ready` and `res_valid` are never high together.
- R12: `res_valid`, `res_kind` and `res_value` stay steady while `res_ready` is low. A register write-back happens exactly once, in the cycle the result is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_mode | input | 3 | Addressing mode code |
| req_dec | input | 1 | Step direction for mode 7 (1 = decrement) |
| req_idx | input | 3 | Base register index |
| req_konst | input | 16 | Instruction constant, address or offset |
| req_pc | input | 16 | Address of the following instruction |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_kind | output | 2 | 0 register operand, 1 immediate, 2 memory address |
| res_value | output | 16 | Operand or address |
| rf_raddr | output | 3 | Register file read index |
| rf_rdata | input | 16 | Register file read data (same cycle) |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | 3 | Register write index |
| rf_wdata | output | 16 | Register write data |
| mem_req | output | 1 | Indirect pointer read pending |
| mem_addr | output | 16 | Pointer location |
| mem_ack | input | 1 | Read data valid pulse |
| mem_rdata | input | 16 | Pointer word read |

## Verification
Every mode except memory-indirect presents its result one cycle after the request is accepted. Memory-indirect raises its read one cycle after acceptance and presents its result one cycle after the ack. The bench drives inputs on falling edges, so it knows the exact cycle each output is due and samples it at the falling edge of that cycle. While the result is held back, it checks on every cycle that the result stays steady and that no register write appears. It then checks the write strobe in the accepting cycle and reads the register back one cycle later, against a behavioural model of the register contents.

// File: rtl/oea_pkg.sv
package oea_pkg;
  typedef enum logic [2:0] {
    M_REG   = 3'd0,
    M_ABS   = 3'd1,
    M_IMM   = 3'd2,
    M_RIND  = 3'd3,
    M_MIND  = 3'd4,
    M_INDEX = 3'd5,
    M_REL   = 3'd6,
    M_AUTO  = 3'd7
  } mode_e;

  typedef enum logic [1:0] {
    K_REG = 2'd0,
    K_IMM = 2'd1,
    K_MEM = 2'd2
  } kind_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_MEM  = 2'd1,
    S_DONE = 2'd2
  } state_e;
endpackage

// File: rtl/oea_addr_calc.sv
module oea_addr_calc
  import oea_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic [2:0]        mode,
  input  logic              dec,
  input  logic [ADDR_W-1:0] reg_val,
  input  logic [ADDR_W-1:0] konst,
  input  logic [ADDR_W-1:0] pc,
  output kind_e             kind,
  output logic [ADDR_W-1:0] value,
  output logic              wb_en,
  output logic [ADDR_W-1:0] wb_val,
  output logic              needs_mem
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  logic [ADDR_W-1:0] stepped_up;
  logic [ADDR_W-1:0] stepped_dn;

  assign stepped_up = reg_val + STEP;
  assign stepped_dn = reg_val - STEP;

  always_comb begin
    kind      = K_MEM;
    value     = '0;
    wb_en     = 1'b0;
    wb_val    = '0;
    needs_mem = 1'b0;
    case (mode_e'(mode))
      M_REG: begin
        kind  = K_REG;
        value = reg_val;
      end
      M_ABS:   value = konst;
      M_IMM: begin
        kind  = K_IMM;
        value = konst;
      end
      M_RIND:  value = reg_val;
      M_MIND:  needs_mem = 1'b1;
      M_INDEX: value = reg_val + konst;
      M_REL:   value = pc + konst;
      M_AUTO: begin
        wb_en = 1'b1;
        if (dec) begin
          value  = stepped_dn;
          wb_val = stepped_dn;
        end else begin
          value  = reg_val;
          wb_val = stepped_up;
        end
      end
      default: value = '0;
    endcase
  end
endmodule

// File: rtl/oea_seq.sv
module oea_seq
  import oea_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [ADDR_W-1:0] req_konst,
  input  kind_e             c_kind,
  input  logic [ADDR_W-1:0] c_value,
  input  logic              c_wb_en,
  input  logic [ADDR_W-1:0] c_wb_val,
  input  logic              c_needs_mem,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [1:0]        res_kind,
  output logic [ADDR_W-1:0] res_value,
  output logic              rf_we,
  output logic [IDX_W-1:0]  rf_waddr,
  output logic [ADDR_W-1:0] rf_wdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [ADDR_W-1:0] mem_rdata
);
  state_e            st;
  kind_e             kind_q;
  logic [ADDR_W-1:0] val_q;
  logic              wb_en_q;
  logic [ADDR_W-1:0] wb_val_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      kind_q   <= K_REG;
      val_q    <= '0;
      wb_en_q  <= 1'b0;
      wb_val_q <= '0;
      idx_q    <= '0;
      ptr_q    <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          idx_q <= req_idx;
          if (c_needs_mem) begin
            ptr_q   <= req_konst;
            wb_en_q <= 1'b0;
            st      <= S_MEM;
          end else begin
            kind_q   <= c_kind;
            val_q    <= c_value;
            wb_en_q  <= c_wb_en;
            wb_val_q <= c_wb_val;
            st       <= S_DONE;
          end
        end
        S_MEM: if (mem_ack) begin
          kind_q <= K_MEM;
          val_q  <= mem_rdata;
          st     <= S_DONE;
        end
        S_DONE: if (res_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (st == S_IDLE);
  assign res_valid = (st == S_DONE);
  assign res_kind  = kind_q;
  assign res_value = val_q;
  assign rf_we     = (st == S_DONE) && res_ready && wb_en_q;
  assign rf_waddr  = idx_q;
  assign rf_wdata  = wb_val_q;
  assign mem_req   = (st == S_MEM);
  assign mem_addr  = ptr_q;
endmodule

// File: rtl/oea_unit.sv
module oea_unit
  import oea_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int WORD_BYTES = 4,
  parameter int REG_COUNT  = 8,
  localparam int IDX_W     = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_mode,
  input  logic              req_dec,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [ADDR_W-1:0] req_konst,
  input  logic [ADDR_W-1:0] req_pc,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [1:0]        res_kind,
  output logic [ADDR_W-1:0] res_value,
  output logic [IDX_W-1:0]  rf_raddr,
  input  logic [ADDR_W-1:0] rf_rdata,
  output logic              rf_we,
  output logic [IDX_W-1:0]  rf_waddr,
  output logic [ADDR_W-1:0] rf_wdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [ADDR_W-1:0] mem_rdata
);
  kind_e             c_kind;
  logic [ADDR_W-1:0] c_value;
  logic              c_wb_en;
  logic [ADDR_W-1:0] c_wb_val;
  logic              c_needs_mem;

  assign rf_raddr = req_idx;

  oea_addr_calc #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_calc (
    .mode(req_mode), .dec(req_dec), .reg_val(rf_rdata), .konst(req_konst),
    .pc(req_pc), .kind(c_kind), .value(c_value), .wb_en(c_wb_en),
    .wb_val(c_wb_val), .needs_mem(c_needs_mem)
  );

  oea_seq #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_idx(req_idx), .req_konst(req_konst), .c_kind(c_kind),
    .c_value(c_value), .c_wb_en(c_wb_en), .c_wb_val(c_wb_val),
    .c_needs_mem(c_needs_mem), .res_valid(res_valid), .res_ready(res_ready),
    .res_kind(res_kind), .res_value(res_value), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );
endmodule

// File: rtl/oea_unit_chk.sv
module oea_unit_chk #(
  parameter int ADDR_W     = 16,
  parameter int WORD_BYTES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              res_valid,
  input logic              res_ready,
  input logic [1:0]        res_kind,
  input logic [ADDR_W-1:0] res_value,
  input logic              rf_we,
  input logic [ADDR_W-1:0] rf_wdata,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  a_r12_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_value) && $stable(res_kind));

  a_r11_ready_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && res_valid));

  a_r6_mem_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  a_r6_mem_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready && !res_valid);

  a_r12_wb_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> res_valid && res_ready && res_kind == 2'd2);

  a_r9_wb_step: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (rf_wdata == res_value) || (rf_wdata == res_value + STEP));
endmodule

bind oea_unit oea_unit_chk #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .res_valid(res_valid),
  .res_ready(res_ready), .res_kind(res_kind), .res_value(res_value),
  .rf_we(rf_we), .rf_wdata(rf_wdata), .mem_req(mem_req),
  .mem_addr(mem_addr), .mem_ack(mem_ack)
);

// File: tb/oea_unit_tb_top.sv
`timescale 1ns/1ps
module oea_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_mode = '0;
  logic        req_dec = 1'b0;
  logic [2:0]  req_idx = '0;
  logic [15:0] req_konst = '0;
  logic [15:0] req_pc = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [1:0]  res_kind;
  logic [15:0] res_value;
  logic [2:0]  rf_raddr;
  logic [15:0] rf_rdata;
  logic        rf_we;
  logic [2:0]  rf_waddr;
  logic [15:0] rf_wdata;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [15:0] mem_rdata = '0;

  logic [15:0] rf [8];
  int          mdl [8];
  int          n_chk = 0;
  int          n_fail = 0;

  always #4 clk = ~clk;

  assign rf_rdata = rf[rf_raddr];
  always @(posedge clk) if (rf_we) rf[rf_waddr] <= rf_wdata;

  oea_unit dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_dec(req_dec), .req_idx(req_idx),
    .req_konst(req_konst), .req_pc(req_pc), .res_valid(res_valid),
    .res_ready(res_ready), .res_kind(res_kind), .res_value(res_value),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic setreg(input int i, input int v);
    rf[i]  = 16'(v);
    mdl[i] = v & 16'hFFFF;
  endtask

  task automatic do_op(input int mode, input int dec, input int idx, input int k,
                       input int pc, input int memval, input int ack_dly,
                       input int hold, input string tag);
    int ekind, eval, ewb, ewbv, r;
    r = mdl[idx];
    ekind = 2; ewb = 0; ewbv = 0;
    case (mode)
      0: begin ekind = 0; eval = r; end
      1: eval = k;
      2: begin ekind = 1; eval = k; end
      3: eval = r;
      4: eval = memval;
      5: eval = (r + k) & 16'hFFFF;
      6: eval = (pc + k) & 16'hFFFF;
      default: begin
        ewb = 1;
        if (dec != 0) begin eval = (r - 4) & 16'hFFFF; ewbv = eval; end
        else begin eval = r; ewbv = (r + 4) & 16'hFFFF; end
      end
    endcase
    @(negedge clk);
    chk(req_ready == 1'b1, {tag, " R11 ready when idle"}, int'(req_ready), 1);
    req_mode = 3'(mode); req_dec = 1'(dec); req_idx = 3'(idx);
    req_konst = 16'(k); req_pc = 16'(pc); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (mode == 4) begin
      chk(mem_req == 1'b1 && res_valid == 1'b0, {tag, " R6 read issued"}, int'(mem_req), 1);
      chk(mem_addr == 16'(k), {tag, " R6 read address"}, int'(mem_addr), k);
      for (int i = 0; i < ack_dly; i++) begin
        @(negedge clk);
        chk(mem_req == 1'b1 && mem_addr == 16'(k) && res_valid == 1'b0,
            {tag, " R6 read held"}, int'(mem_addr), k);
      end
      mem_ack = 1'b1; mem_rdata = 16'(memval);
      @(negedge clk);
      mem_ack = 1'b0; mem_rdata = 16'h0;
      chk(mem_req == 1'b0, {tag, " R6 read released"}, int'(mem_req), 0);
    end
    chk(res_valid == 1'b1, {tag, " R11 result due"}, int'(res_valid), 1);
    chk(int'(res_kind) == ekind, {tag, " kind"}, int'(res_kind), ekind);
    chk(int'(res_value) == eval, {tag, " value"}, int'(res_value), eval);
    for (int i = 0; i < hold; i++) begin
      chk(rf_we == 1'b0, {tag, " R12 no write while stalled"}, int'(rf_we), 0);
      @(negedge clk);
      chk(res_valid == 1'b1 && int'(res_value) == eval && int'(res_kind) == ekind,
          {tag, " R12 result held"}, int'(res_value), eval);
    end
    res_ready = 1'b1;
    #1;
    chk(int'(rf_we) == ewb, {tag, " write strobe"}, int'(rf_we), ewb);
    if (ewb != 0) begin
      chk(int'(rf_waddr) == idx && int'(rf_wdata) == ewbv, {tag, " write data"},
          int'(rf_wdata), ewbv);
      mdl[idx] = ewbv;
    end
    @(negedge clk);
    res_ready = 1'b0;
    chk(res_valid == 1'b0 && req_ready == 1'b1, {tag, " R11 back to idle"},
        int'(res_valid), 0);
    chk(int'(rf[idx]) == mdl[idx], {tag, " register content"}, int'(rf[idx]), mdl[idx]);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) setreg(i, 16'h0100 * i + 16'h10);
    repeat (2) @(negedge clk);
    chk(req_ready == 1'b1 && res_valid == 1'b0 && mem_req == 1'b0 && rf_we == 1'b0,
        "R1 reset outputs", {req_ready, res_valid, mem_req, rf_we}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && res_valid == 1'b0 && mem_req == 1'b0,
        "R1 after reset", {req_ready, res_valid, mem_req}, 3'b100);
    setreg(1, 1000);
    setreg(2, 16'h0ABC);
    setreg(3, 16'h7777);
    setreg(4, 16'h0200);
    setreg(5, 16'h0300);
    setreg(6, 16'hFFF0);
    setreg(7, 16'h0002);
    do_op(0, 0, 3, 16'h5555, 0, 0, 0, 0, "R2 register");
    do_op(1, 0, 2, 16'h1234, 0, 0, 0, 1, "R3 absolute");
    do_op(2, 0, 2, 16'hBEEF, 0, 0, 0, 0, "R4 immediate");
    do_op(3, 0, 2, 16'h0000, 0, 0, 0, 0, "R5 reg indirect");
    do_op(4, 0, 0, 16'h0040, 0, 16'h2222, 2, 0, "R6 mem indirect slow");
    do_op(4, 0, 0, 16'h0080, 0, 16'h9ABC, 0, 1, "R6 mem indirect fast");
    do_op(5, 0, 1, 20, 0, 0, 0, 2, "R7 indexed");
    do_op(5, 0, 6, 16'h0020, 0, 0, 0, 0, "R7 indexed wrap");
    do_op(6, 0, 0, 16'hFFF8, 16'h0104, 0, 0, 0, "R8 relative back");
    do_op(6, 0, 0, 16'h0010, 16'hFFF8, 0, 0, 0, "R8 relative wrap");
    do_op(7, 0, 4, 0, 0, 0, 0, 3, "R9 autoinc stalled");
    do_op(7, 0, 4, 0, 0, 0, 0, 0, "R9 autoinc again");
    do_op(7, 1, 5, 0, 0, 0, 0, 0, "R10 autodec");
    do_op(7, 1, 7, 0, 0, 0, 0, 2, "R10 autodec wrap");
    do_op(3, 0, 7, 0, 0, 0, 0, 0, "R12 single write-back");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule